// File: doc/BRIEF.md
# Timer channel with emergency-stop interlock

This block is a single up-counting timer channel that drives a complementary pulse pair. Software arms it by writing a run request. Counting then begins at the next falling edge of an external event input. While it counts, the counter steps from zero up to a programmable period and wraps back to zero. The positive output is high while the count is below a programmable compare value, and the negative output is its complement. Whenever the channel is not counting, both outputs are held low.

A separate safety path watches one of several emergency inputs, chosen by a select field and gated by an enable bit. A rising edge on the chosen input does the following:
- withdraws the run request;
- latches an emergency flag, which forces both outputs low at once;
- halts the counter one clock later, and the counting status drops at that point.

The counter keeps its value through the stop. While the flag is set, event edges are ignored. A run request is refused while the counting status is still high. Software clears the flag with a write-one strobe, sets the run request again, and waits for an event edge. Counting then resumes from the held value.

Top module: `estop_timer`

## Requirements
- R1: After reset, run request, counting status, emergency flag, count, both outputs and the interrupt line are all 0.
- R2: While counting, the count increments by one per clock and goes from the period value to 0 on the next clock.
- R3: While counting with the flag clear, out_p is 1 exactly when count < compare and out_n is its complement. When not counting, or when the flag is set, both are 0.
- R4: A falling edge on evt_in starts counting only when the run request is 1, the channel is not counting and the flag is clear. The counting status is visible 3 clocks after the input changes: 2 synchronizer stages plus the edge register.
- R5: With the enable bit set, a rising edge on the emergency input picked by cfg_emg_sel (0 selects bit 0, 1 selects bit 1) clears the run request and sets the flag 3 clocks after the input changes. Both outputs go low in that same cycle.
- R6: Once the run request is cleared while counting, the counter advances one more clock, then the counting status drops to 0 and the count holds its value.
- R7: A run-set strobe issued while the counting status is 1 leaves the run request at 0.
- R8: While the flag is set, event falling edges do not start counting, even with the run request at 1.
- R9: A clr_wr strobe clears the flag. If an emergency edge and a clr_wr strobe land in the same cycle, the flag ends up set.
- R10: irq_o equals the flag ANDed with cfg_irq_en.
- R11: After the flag is cleared and the run request is set again, an event edge restarts counting from the held count, without reloading it.
- R12: Emergency edges have no effect while the enable bit is 0, or when they arrive on an input that is not selected.
- R13: A run-clear strobe while counting stops the channel with the same one-clock sequence as R6, and leaves the flag at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_emg_en | input | 1 | Emergency path enable |
| cfg_emg_sel | input | SEL_W | Emergency source select |
| cfg_irq_en | input | 1 | Interrupt enable |
| cfg_period | input | CNT_W | Last count value before wrap |
| cfg_cmp | input | CNT_W | Compare value for out_p |
| run_set_wr | input | 1 | Strobe: request RUN = 1 |
| run_clr_wr | input | 1 | Strobe: request RUN = 0 |
| clr_wr | input | 1 | Strobe: clear emergency flag (write one) |
| evt_in | input | 1 | Asynchronous event trigger |
| emg_in | input | NSRC | Asynchronous emergency trigger sources |
| run_o | output | 1 | Run request bit |
| stat_o | output | 1 | Counting status |
| flag_o | output | 1 | Emergency stop flag |
| cnt_o | output | CNT_W | Current count |
| out_p | output | 1 | Positive pulse output |
| out_n | output | 1 | Negative pulse output |
| irq_o | output | 1 | Interrupt line |

## Verification
The bench first walks a wrap-around count sequence. It then checks the exact held count after an emergency stop: a design that halts at once, or one that clears the counter, would show a different value there. It attempts a run request during the one-clock stop window and an event edge while the flag is set, either of which would wrongly restart a broken interlock. It lines up an emergency edge with a clear strobe in the same cycle, which would leave the flag low if the priority were reversed. It also fires edges on the unselected source and with the path disabled, where a bad multiplexer or gate would stop the channel.

// File: rtl/estop_pkg.sv
package estop_pkg;
    typedef struct packed {
        logic run;
        logic stat;
        logic pend;
        logic flag;
    } ctl_t;
endpackage

// File: rtl/estop_edge.sv
module estop_edge #(
    parameter bit FALL = 1'b0,
    parameter bit INIT = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic pulse
);
    // [0] first stage, [1] second stage, [2] previous sample
    logic [2:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[1], sh_q[0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= {3{INIT}};
        else        sh_q <= sh_d;
    end

    generate
        if (FALL) begin : g_fall
            assign pulse = ~sh_q[1] & sh_q[2];
        end else begin : g_rise
            assign pulse = sh_q[1] & ~sh_q[2];
        end
    endgenerate

    // R4
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |=> !pulse);
endmodule

// File: rtl/estop_ctl.sv
module estop_ctl
    import estop_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic run_set,
    input  logic run_clr,
    input  logic clr,
    input  logic emg_hit,
    input  logic evt_hit,
    output logic run,
    output logic stat,
    output logic flag
);
    ctl_t d, q;

    always_comb begin
        d = q;
        if (q.pend) begin
            d.stat = 1'b0;
            d.pend = 1'b0;
        end else if (evt_hit && q.run && !q.stat && !q.flag && !emg_hit && !run_clr) begin
            d.stat = 1'b1;
        end
        if (emg_hit) begin
            d.run  = 1'b0;
            d.flag = 1'b1;
            if (q.stat && !q.pend) d.pend = 1'b1;
        end else begin
            if (clr) d.flag = 1'b0;
            if (run_clr && q.run) begin
                d.run = 1'b0;
                if (q.stat && !q.pend) d.pend = 1'b1;
            end else if (run_set && !q.stat) begin
                d.run = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign run  = q.run;
    assign stat = q.stat;
    assign flag = q.flag;

    // R5
    emg_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        emg_hit |=> (q.flag && !q.run));
    // R6
    stop_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(q.run) && q.stat) |=> !q.stat);
    // R7
    run_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_set && q.stat) |=> !$rose(q.run));
    // R8
    evt_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.flag && !q.stat) |=> !q.stat);
endmodule

// File: rtl/estop_cnt.sv
module estop_cnt #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             active,
    input  logic [CNT_W-1:0] period,
    input  logic [CNT_W-1:0] cmp,
    output logic [CNT_W-1:0] cnt,
    output logic             out_p,
    output logic             out_n
);
    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic             below;

    always_comb begin
        cnt_d = cnt_q;
        if (en) cnt_d = (cnt_q >= period) ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign below = (cnt_q < cmp);
    assign cnt   = cnt_q;
    assign out_p = active & below;
    assign out_n = active & ~below;

    // R2
    wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && cnt_q == period) |=> (cnt_q == '0));
    // R6
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(cnt_q));
endmodule

// File: rtl/estop_timer.sv
module estop_timer #(
    parameter int CNT_W = 8,
    parameter int NSRC  = 2,
    localparam int SEL_W = (NSRC > 1) ? $clog2(NSRC) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_emg_en,
    input  logic [SEL_W-1:0] cfg_emg_sel,
    input  logic             cfg_irq_en,
    input  logic [CNT_W-1:0] cfg_period,
    input  logic [CNT_W-1:0] cfg_cmp,
    input  logic             run_set_wr,
    input  logic             run_clr_wr,
    input  logic             clr_wr,
    input  logic             evt_in,
    input  logic [NSRC-1:0]  emg_in,
    output logic             run_o,
    output logic             stat_o,
    output logic             flag_o,
    output logic [CNT_W-1:0] cnt_o,
    output logic             out_p,
    output logic             out_n,
    output logic             irq_o
);
    logic emg_raw, emg_pulse, evt_pulse, emg_hit;

    assign emg_raw = (int'(cfg_emg_sel) < NSRC) ? emg_in[cfg_emg_sel] : 1'b0;

    estop_edge #(.FALL(1'b0), .INIT(1'b0)) u_emg_edge (
        .clk(clk), .rst_n(rst_n), .din(emg_raw), .pulse(emg_pulse));

    estop_edge #(.FALL(1'b1), .INIT(1'b0)) u_evt_edge (
        .clk(clk), .rst_n(rst_n), .din(evt_in), .pulse(evt_pulse));

    assign emg_hit = emg_pulse & cfg_emg_en;

    estop_ctl u_ctl (
        .clk(clk), .rst_n(rst_n),
        .run_set(run_set_wr), .run_clr(run_clr_wr), .clr(clr_wr),
        .emg_hit(emg_hit), .evt_hit(evt_pulse),
        .run(run_o), .stat(stat_o), .flag(flag_o));

    estop_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n),
        .en(stat_o), .active(stat_o & ~flag_o),
        .period(cfg_period), .cmp(cfg_cmp),
        .cnt(cnt_o), .out_p(out_p), .out_n(out_n));

    assign irq_o = flag_o & cfg_irq_en;

    // R3
    out_safe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flag_o |-> !(out_p || out_n));
endmodule

// File: tb/sim_estop_timer.sv
module sim_estop_timer;
    localparam int CNT_W = 8;
    localparam int NSRC  = 2;
    localparam int PER   = 9;
    localparam int CMPV  = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic emg_en = 1'b0, irq_en = 1'b0;
    logic [0:0] emg_sel = '0;
    logic [CNT_W-1:0] period = '0, cmpv = '0;
    logic run_set = 1'b0, run_clr = 1'b0, clr = 1'b0, evt = 1'b1;
    logic [NSRC-1:0] emg = '0;
    logic run_o, stat_o, flag_o, out_p, out_n, irq_o;
    logic [CNT_W-1:0] cnt_o;

    int tests = 0;
    int fails = 0;

    always #4 clk = ~clk;

    estop_timer #(.CNT_W(CNT_W), .NSRC(NSRC)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_emg_en(emg_en), .cfg_emg_sel(emg_sel),
        .cfg_irq_en(irq_en), .cfg_period(period), .cfg_cmp(cmpv),
        .run_set_wr(run_set), .run_clr_wr(run_clr), .clr_wr(clr),
        .evt_in(evt), .emg_in(emg), .run_o(run_o), .stat_o(stat_o),
        .flag_o(flag_o), .cnt_o(cnt_o), .out_p(out_p), .out_n(out_n), .irq_o(irq_o));

    // wait, count after start, expected out_p
    typedef struct packed { logic [7:0] w; logic [7:0] c; logic p; } vec_t;
    localparam vec_t VECS [6] = '{
        '{8'd1, 8'd1, 1'b1}, '{8'd3, 8'd4, 1'b0}, '{8'd5, 8'd9, 1'b0},
        '{8'd1, 8'd0, 1'b1}, '{8'd2, 8'd2, 1'b1}, '{8'd1, 8'd3, 1'b1}};

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic strobe(ref logic s);
        s = 1'b1; tick(1); s = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got %0d expected %0d", 1, 0);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int c;
        tick(3);
        rst_n = 1'b1;
        tick(1);
        // R1 reset state
        chk("R1 run", run_o, 0); chk("R1 stat", stat_o, 0); chk("R1 flag", flag_o, 0);
        chk("R1 cnt", cnt_o, 0); chk("R1 outp", out_p, 0); chk("R1 outn", out_n, 0);
        chk("R1 irq", irq_o, 0);
        tick(3);
        period = PER; cmpv = CMPV; emg_sel = 0; emg_en = 1; irq_en = 1;
        strobe(run_set);
        chk("R4 run armed", run_o, 1);
        evt = 1'b0;
        tick(2);
        chk("R4 stat not yet", stat_o, 0);
        tick(1);
        chk("R4 stat started", stat_o, 1);
        chk("R4 cnt start", cnt_o, 0);
        // R2 / R3 vector walk
        foreach (VECS[i]) begin
            tick(VECS[i].w);
            chk("R2 count", cnt_o, VECS[i].c);
            chk("R3 out_p", out_p, VECS[i].p);
            chk("R3 out_n", out_n, !VECS[i].p);
        end
        // R5 emergency
        c = cnt_o;
        emg[0] = 1'b1;
        tick(3);
        chk("R5 run cleared", run_o, 0); chk("R5 flag", flag_o, 1);
        chk("R5 outp low", out_p, 0); chk("R5 outn low", out_n, 0);
        chk("R6 stat still", stat_o, 1);
        chk("R10 irq", irq_o, 1);
        strobe(run_set);
        chk("R6 stat dropped", stat_o, 0);
        chk("R7 run refused", run_o, 0);
        chk("R6 held cnt", cnt_o, (c + 4) % (PER + 1));
        tick(3);
        chk("R6 still held", cnt_o, (c + 4) % (PER + 1));
        c = (c + 4) % (PER + 1);
        // R8 event blocked while flag set
        strobe(run_set);
        chk("R8 run set", run_o, 1);
        evt = 1'b1; tick(3); evt = 1'b0; tick(4);
        chk("R8 stat blocked", stat_o, 0);
        chk("R8 cnt held", cnt_o, c);
        irq_en = 0; tick(1);
        chk("R10 irq masked", irq_o, 0);
        irq_en = 1;
        strobe(clr);
        chk("R9 flag cleared", flag_o, 0); chk("R10 irq off", irq_o, 0);
        emg[0] = 1'b0;
        // R11 restart from held value
        evt = 1'b1; tick(3); evt = 1'b0; tick(3);
        chk("R11 restarted", stat_o, 1); chk("R11 held start", cnt_o, c);
        tick(1);
        chk("R11 next", cnt_o, (c + 1) % (PER + 1));
        chk("R3 outp", out_p, ((c + 1) % (PER + 1)) < CMPV);
        chk("R3 outn", out_n, !(((c + 1) % (PER + 1)) < CMPV));
        // R12 disabled and unselected
        emg_en = 0; emg[0] = 1'b1; tick(5);
        chk("R12 disabled flag", flag_o, 0); chk("R12 disabled stat", stat_o, 1);
        emg[0] = 1'b0; tick(3);
        emg_en = 1; emg_sel = 1;
        emg[0] = 1'b1; tick(5);
        chk("R12 unselected flag", flag_o, 0); chk("R12 unselected run", run_o, 1);
        emg[0] = 1'b0;
        // R9 edge beats clear in the same cycle
        emg[1] = 1'b1; tick(2);
        clr = 1'b1; tick(1); clr = 1'b0;
        chk("R9 edge wins", flag_o, 1);
        chk("R5 sel1 run", run_o, 0);
        tick(1);
        chk("R6 sel1 stat", stat_o, 0);
        // R13 normal stop
        strobe(clr);
        emg[1] = 1'b0;
        evt = 1'b1; tick(3);
        strobe(run_set);
        evt = 1'b0; tick(3);
        chk("R13 running", stat_o, 1);
        c = cnt_o;
        strobe(run_clr);
        chk("R13 run off", run_o, 0); chk("R13 stat still", stat_o, 1);
        tick(1);
        chk("R13 stat off", stat_o, 0); chk("R13 flag", flag_o, 0);
        chk("R13 outp", out_p, 0); chk("R13 outn", out_n, 0);
        chk("R13 cnt", cnt_o, (c + 2) % (PER + 1));
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule